// File: doc/BRIEF.md
# Operand Address Generator

This block turns an addressing mode and the operand bytes that follow an opcode into the effective data address for an 8-bit CPU. It runs as a small sequencer. Modes whose address comes straight from the operand bytes finish one cycle after the start pulse. The two pointer modes first read a 16-bit pointer from page-zero RAM and then finish. A read-modify-write access adds one write-back cycle at the same address. Instruction decode and the ALU sit outside the block. Decode supplies the mode, the access kind, the index select and, for branches, the taken flag. The CPU's data memory port acts on the read and write strobes.

The states are IDLE, PTR_LO, PTR_HI, PTR_END, DONE and WRBACK. Their transitions are:

- IDLE goes to DONE on a start in a direct mode, or to PTR_LO on a start in a pointer mode.
- PTR_LO goes to PTR_HI, which goes to PTR_END, which goes to DONE.
- DONE goes to WRBACK when the access is read-modify-write, and to IDLE otherwise.
- WRBACK goes to IDLE.

Page-zero RAM answers one cycle after a read request. A build-time option stores pointers on even addresses spread over pages 00 and 01.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, done, zp_rd, mem_rd and mem_wr are 0, data_addr is 0 and acc_type is 0 (none).
- R2: Immediate mode (code 0) yields pc+1 with acc_type read (1). done is high the cycle after start, and no page-zero read is made.
- R3: Absolute mode (code 1) yields {opnd_hi, opnd_lo}, low byte first. Page-zero mode (code 3) yields {8'h00, opnd_lo}. Both finish the cycle after start.
- R4: Absolute indexed mode (code 2) adds the index to the full 16-bit address, with carry into the high byte. idx_sel 0 picks X and 1 picks Y.
- R5: Page-zero indexed mode (code 4) adds the selected index to opnd_lo modulo 256, so the address stays in page 00.
- R6: In mode (zp,X) (code 5), the low pointer byte is read at zp_addr = (opnd_lo+X) mod 256 and the high byte at that address +1 without wrap (0xFF is followed by 0x100). The result is {high, low}.
- R7: In mode (zp),Y (code 6), the pointer is read at opnd_lo and opnd_lo+1, and Y is added to it as a 16-bit value.
- R8: With ALIGN_PTR=1, pointer slot s is read at zp_addr 2s (low byte) and 2s+1 (high byte).
- R9: Relative mode (code 7) yields pc plus the sign-extended opnd_lo when taken=1 and pc+2 otherwise. acc_type is none (0) and no memory strobe is raised.
- R10: done is high for exactly one cycle per accepted start. A pointer mode asserts done on the fourth cycle after the start edge, after two page-zero reads on consecutive cycles.
- R11: Access kinds are 1 read, 2 write and 3 read-modify-write. A read raises mem_rd with done, and a write raises mem_wr with done. A read-modify-write raises mem_rd with done and then mem_wr in the next cycle at the same data_addr.
- R12: A start that arrives while the block is busy (not IDLE) is ignored, and the running sequence finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation (accepted in IDLE) |
| mode | input | 3 | Addressing mode code |
| kind | input | 2 | Access kind from decode |
| idx_sel | input | 1 | Index for indexed modes: 0 X, 1 Y |
| taken | input | 1 | Branch condition met (relative mode) |
| pc | input | 16 | Address of the current opcode |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| zp_rdata | input | 8 | Page-zero read data, one cycle after zp_rd |
| zp_rd | output | 1 | Page-zero read request |
| zp_addr | output | 9 | Page-zero RAM address (pages 00 and 01) |
| data_addr | output | 16 | Effective data address |
| acc_type | output | 2 | Access kind of the finished address |
| done | output | 1 | One-cycle strobe: data_addr is final |
| mem_rd | output | 1 | Data read strobe |
| mem_wr | output | 1 | Data write strobe |

## Verification
The bound checker watches several properties on every cycle:

- done lasts a single cycle.
- A read strobe appears only together with done.
- A lone write strobe follows a read at an unchanged address.
- The second pointer read targets the address just after the first.
- With alignment on, the first pointer read lands on an even address.
- No page-zero read overlaps the done strobe.

Only the bench's scenarios show that the address values are right. These include carry across a page in absolute indexing, wrap in page-zero indexing, the 0xFF-to-0x100 pointer fetch, backward and forward branches, and an ignored start in mid-sequence. The bench checks these for both the flat and the aligned pointer layout at once.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_ABS  = 3'd1,
        M_ABSI = 3'd2,
        M_ZP   = 3'd3,
        M_ZPI  = 3'd4,
        M_INDX = 3'd5,
        M_INDY = 3'd6,
        M_REL  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_RMW   = 2'd3
    } akind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_LO,
        S_PTR_HI,
        S_PTR_END,
        S_DONE,
        S_WRBACK
    } st_e;
endpackage

// File: rtl/ea_ptr_addr.sv
// Maps a page-zero pointer slot and a byte select onto the pointer RAM address.
module ea_ptr_addr #(
    parameter int DW        = 8,
    parameter bit ALIGN_PTR = 1'b0
) (
    input  logic [DW-1:0] slot,
    input  logic          upper,
    output logic [DW:0]   zaddr
);
    generate
        if (ALIGN_PTR) begin : g_align
            // pointers sit on even addresses across pages 00 and 01
            assign zaddr = {slot, upper};
        end else begin : g_flat
            // high byte fetch does not wrap inside page 00
            assign zaddr = {1'b0, slot} + {{DW{1'b0}}, upper};
        end
    endgenerate
endmodule

// File: rtl/ea_direct_calc.sv
// Effective address for the modes that need no pointer fetch.
module ea_direct_calc
    import ea_pkg::*;
#(
    parameter int DW = 8
) (
    input  amode_e          mode,
    input  logic            taken,
    input  logic [2*DW-1:0] pc,
    input  logic [DW-1:0]   lo,
    input  logic [DW-1:0]   hi,
    input  logic [DW-1:0]   idx,
    output logic [2*DW-1:0] addr
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] abs_a;
    logic [AW-1:0] idx_w;
    logic [AW-1:0] rel_off;
    logic [DW-1:0] zp_sum;

    assign abs_a   = {hi, lo};
    assign idx_w   = {{DW{1'b0}}, idx};
    assign rel_off = {{DW{lo[DW-1]}}, lo};
    assign zp_sum  = lo + idx;

    always_comb begin
        unique case (mode)
            M_IMM:          addr = pc + AW'(1);
            M_ABS:          addr = abs_a;
            M_ABSI:         addr = abs_a + idx_w;
            M_ZP:           addr = {{DW{1'b0}}, lo};
            M_ZPI:          addr = {{DW{1'b0}}, zp_sum};
            M_REL:          addr = taken ? (pc + rel_off) : (pc + AW'(2));
            M_INDX, M_INDY: addr = '0;
            default:        addr = '0;
        endcase
    end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int DW        = 8,
    parameter bit ALIGN_PTR = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic [1:0]      kind,
    input  logic            idx_sel,
    input  logic            taken,
    input  logic [2*DW-1:0] pc,
    input  logic [DW-1:0]   opnd_lo,
    input  logic [DW-1:0]   opnd_hi,
    input  logic [DW-1:0]   idx_x,
    input  logic [DW-1:0]   idx_y,
    input  logic [DW-1:0]   zp_rdata,
    output logic            zp_rd,
    output logic [DW:0]     zp_addr,
    output logic [2*DW-1:0] data_addr,
    output logic [1:0]      acc_type,
    output logic            done,
    output logic            mem_rd,
    output logic            mem_wr
);
    localparam int AW = 2 * DW;

    st_e           state, state_nx;
    amode_e        mode_in;
    amode_e        mode_q;
    akind_e        type_q;
    akind_e        type_in;
    logic [DW-1:0] slot_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] y_q;
    logic [DW-1:0] idx_pick;
    logic [AW-1:0] direct_addr;
    logic          is_ptr_mode;
    logic          accept;

    assign mode_in     = amode_e'(mode);
    assign idx_pick    = idx_sel ? idx_y : idx_x;
    assign is_ptr_mode = (mode_in == M_INDX) || (mode_in == M_INDY);
    assign accept      = (state == S_IDLE) && start;

    always_comb begin
        unique case (mode_in)
            M_IMM:   type_in = K_READ;
            M_REL:   type_in = K_NONE;
            default: type_in = akind_e'(kind);
        endcase
    end

    ea_direct_calc #(.DW(DW)) u_direct (
        .mode  (mode_in),
        .taken (taken),
        .pc    (pc),
        .lo    (opnd_lo),
        .hi    (opnd_hi),
        .idx   (idx_pick),
        .addr  (direct_addr)
    );

    ea_ptr_addr #(.DW(DW), .ALIGN_PTR(ALIGN_PTR)) u_ptr (
        .slot  (slot_q),
        .upper (state == S_PTR_HI),
        .zaddr (zp_addr)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = is_ptr_mode ? S_PTR_LO : S_DONE;
            S_PTR_LO:  state_nx = S_PTR_HI;
            S_PTR_HI:  state_nx = S_PTR_END;
            S_PTR_END: state_nx = S_DONE;
            S_DONE:    state_nx = (type_q == K_RMW) ? S_WRBACK : S_IDLE;
            S_WRBACK:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_IMM;
            type_q    <= K_NONE;
            slot_q    <= '0;
            lo_q      <= '0;
            y_q       <= '0;
            data_addr <= '0;
        end else begin
            if (accept) begin
                mode_q    <= mode_in;
                type_q    <= type_in;
                y_q       <= idx_y;
                data_addr <= direct_addr;
                slot_q    <= (mode_in == M_INDX) ? DW'(opnd_lo + idx_x) : opnd_lo;
            end
            if (state == S_PTR_HI) lo_q <= zp_rdata;
            if (state == S_PTR_END)
                data_addr <= {zp_rdata, lo_q}
                           + {{DW{1'b0}}, (mode_q == M_INDY) ? y_q : {DW{1'b0}}};
        end
    end

    // outputs
    always_comb begin
        zp_rd    = 1'b0;
        done     = 1'b0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        acc_type = type_q;
        unique case (state)
            S_PTR_LO, S_PTR_HI: zp_rd = 1'b1;
            S_DONE: begin
                done   = 1'b1;
                mem_rd = (type_q == K_READ) || (type_q == K_RMW);
                mem_wr = (type_q == K_WRITE);
            end
            S_WRBACK: mem_wr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk #(
    parameter int DW        = 8,
    parameter bit ALIGN_PTR = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            zp_rd,
    input logic [DW:0]     zp_addr,
    input logic [2*DW-1:0] data_addr,
    input logic [1:0]      acc_type,
    input logic            done,
    input logic            mem_rd,
    input logic            mem_wr
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_read_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> done);

    a_r11_writeback_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !done) |-> ($past(mem_rd) && (acc_type == 2'd3) && $stable(data_addr)));

    a_r9_none_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (done && acc_type == 2'd0) |-> (!mem_rd && !mem_wr));

    a_r6_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (zp_rd && $past(zp_rd)) |-> (zp_addr == (DW+1)'($past(zp_addr) + 1'b1)));

    a_r8_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ALIGN_PTR && zp_rd && !$past(zp_rd)) |-> !zp_addr[0]);

    a_r10_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        zp_rd |-> (!done && !mem_rd && !mem_wr));
endmodule

bind ea_sequencer ea_sequencer_chk #(.DW(DW), .ALIGN_PTR(ALIGN_PTR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .zp_rd     (zp_rd),
    .zp_addr   (zp_addr),
    .data_addr (data_addr),
    .acc_type  (acc_type),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/tb_ea_sequencer.sv
`timescale 1ns/1ps
module tb_ea_sequencer;
    typedef struct packed {
        logic        zr;
        logic [8:0]  za;
        logic        dn;
        logic        mr;
        logic        mw;
        logic [15:0] ad;
        logic [1:0]  ty;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic [1:0] kind = '0;
    logic idx_sel = 1'b0, taken = 1'b0;
    logic [15:0] pc = '0;
    logic [7:0] lo = '0, hi = '0, xv = '0, yv = '0;
    logic [7:0] rd0 = '0, rd1 = '0;

    logic zr0, zr1, dn0, dn1, mr0, mr1, mw0, mw1;
    logic [8:0] za0, za1;
    logic [15:0] ad0, ad1;
    logic [1:0] ty0, ty1;

    exp_t q0[$];
    exp_t q1[$];
    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ea_sequencer #(.DW(8), .ALIGN_PTR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .kind(kind),
        .idx_sel(idx_sel), .taken(taken), .pc(pc), .opnd_lo(lo), .opnd_hi(hi),
        .idx_x(xv), .idx_y(yv), .zp_rdata(rd0), .zp_rd(zr0), .zp_addr(za0),
        .data_addr(ad0), .acc_type(ty0), .done(dn0), .mem_rd(mr0), .mem_wr(mw0));

    ea_sequencer #(.DW(8), .ALIGN_PTR(1'b1)) dut_al (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .kind(kind),
        .idx_sel(idx_sel), .taken(taken), .pc(pc), .opnd_lo(lo), .opnd_hi(hi),
        .idx_x(xv), .idx_y(yv), .zp_rdata(rd1), .zp_rd(zr1), .zp_addr(za1),
        .data_addr(ad1), .acc_type(ty1), .done(dn1), .mem_rd(mr1), .mem_wr(mw1));

    function automatic logic [7:0] zpv(input logic [8:0] a);
        int v;
        v = (int'(a) * 37 + 11) % 256;
        return 8'(v);
    endfunction

    // page-zero RAM models: data one cycle after the request
    always @(posedge clk) begin
        if (zr0) rd0 <= zpv(za0);
        if (zr1) rd1 <= zpv(za1);
    end

    task automatic push(input int al, input exp_t e);
        if (al != 0) q1.push_back(e);
        else         q0.push_back(e);
    endtask

    // behavioural reference: expected output trace for one accepted start
    task automatic plan(input int al);
        exp_t e;
        int typ, slot, la, ha, ptr, addr, idx, off;
        typ = (mode == 3'd0) ? 1 : (mode == 3'd7) ? 0 : int'(kind);
        idx = idx_sel ? int'(yv) : int'(xv);
        if (mode == 3'd5 || mode == 3'd6) begin
            slot = (mode == 3'd5) ? ((int'(lo) + int'(xv)) % 256) : int'(lo);
            la = (al != 0) ? slot * 2 : slot;
            ha = la + 1;
            e = '0; e.zr = 1'b1; e.za = 9'(la); push(al, e);
            e = '0; e.zr = 1'b1; e.za = 9'(ha); push(al, e);
            e = '0; push(al, e);
            ptr = int'(zpv(9'(ha))) * 256 + int'(zpv(9'(la)));
            addr = (ptr + ((mode == 3'd6) ? int'(yv) : 0)) % 65536;
        end else begin
            case (mode)
                3'd0: addr = (int'(pc) + 1) % 65536;
                3'd1: addr = int'(hi) * 256 + int'(lo);
                3'd2: addr = (int'(hi) * 256 + int'(lo) + idx) % 65536;
                3'd3: addr = int'(lo);
                3'd4: addr = (int'(lo) + idx) % 256;
                default: begin
                    off = (lo > 8'd127) ? int'(lo) - 256 : int'(lo);
                    addr = taken ? (int'(pc) + off + 65536) % 65536 : (int'(pc) + 2) % 65536;
                end
            endcase
        end
        e = '0; e.dn = 1'b1; e.mr = (typ == 1 || typ == 3); e.mw = (typ == 2);
        e.ad = 16'(addr); e.ty = 2'(typ);
        push(al, e);
        if (typ == 3) begin
            e = '0; e.mw = 1'b1; e.ad = 16'(addr); e.ty = 2'd3;
            push(al, e);
        end
    endtask

    task automatic cmp_one(input int al, input exp_t e, input logic zr, input logic [8:0] za,
                           input logic dn, input logic mr, input logic mw,
                           input logic [15:0] ad, input logic [1:0] ty);
        logic bad;
        bad = (zr !== e.zr) || (dn !== e.dn) || (mr !== e.mr) || (mw !== e.mw);
        if (e.zr && za !== e.za) bad = 1'b1;
        if ((e.dn || e.mw) && (ad !== e.ad || ty !== e.ty)) bad = 1'b1;
        vectors++;
        if (bad) begin
            fails++;
            $display("FAIL %s align=%0d t=%0t got zr=%b za=%h dn=%b rd=%b wr=%b ad=%h ty=%0d exp zr=%b za=%h dn=%b rd=%b wr=%b ad=%h ty=%0d",
                     cur_req, al, $time, zr, za, dn, mr, mw, ad, ty,
                     e.zr, e.za, e.dn, e.mr, e.mw, e.ad, e.ty);
        end
    endtask

    task automatic tick();
        exp_t e0, e1;
        @(negedge clk);
        e0 = (q0.size() > 0) ? q0.pop_front() : '0;
        e1 = (q1.size() > 0) ? q1.pop_front() : '0;
        cmp_one(0, e0, zr0, za0, dn0, mr0, mw0, ad0, ty0);
        cmp_one(1, e1, zr1, za1, dn1, mr1, mw1, ad1, ty1);
    endtask

    task automatic launch(input logic [2:0] m, input logic [1:0] k, input logic s, input logic t,
                          input logic [15:0] p, input logic [7:0] l, input logic [7:0] h,
                          input logic [7:0] x, input logic [7:0] y);
        mode = m; kind = k; idx_sel = s; taken = t; pc = p; lo = l; hi = h; xv = x; yv = y;
        start = 1'b1;
        plan(0);
        plan(1);
        tick();
        start = 1'b0;
    endtask

    task automatic drain();
        while (q0.size() > 0 || q1.size() > 0) tick();
        tick();
    endtask

    task automatic run(input string req, input logic [2:0] m, input logic [1:0] k,
                       input logic s, input logic t, input logic [15:0] p,
                       input logic [7:0] l, input logic [7:0] h,
                       input logic [7:0] x, input logic [7:0] y);
        cur_req = req;
        launch(m, k, s, t, p, l, h, x, y);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle outputs at zero
        cur_req = "R1";
        tick();
        vectors++;
        if (ad0 !== 16'h0 || ty0 !== 2'd0 || ad1 !== 16'h0 || ty1 !== 2'd0) begin
            fails++;
            $display("FAIL R1 got ad=%h/%h ty=%0d/%0d expected 0000 and 0", ad0, ad1, ty0, ty1);
        end
        tick();

        run("R2", 3'd0, 2'd2, 1'b0, 1'b0, 16'h1234, 8'h55, 8'h66, 8'h01, 8'h02);
        run("R2", 3'd0, 2'd0, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 8'h00);
        run("R3", 3'd1, 2'd1, 1'b0, 1'b0, 16'h0200, 8'h34, 8'h12, 8'h00, 8'h00);
        run("R3", 3'd3, 2'd2, 1'b0, 1'b0, 16'h0200, 8'h80, 8'h99, 8'h00, 8'h00);
        run("R4", 3'd2, 2'd1, 1'b0, 1'b0, 16'h0300, 8'hF0, 8'h12, 8'h20, 8'h07);
        run("R4", 3'd2, 2'd1, 1'b1, 1'b0, 16'h0300, 8'hF0, 8'hFF, 8'h03, 8'h20);
        run("R5", 3'd4, 2'd1, 1'b0, 1'b0, 16'h0300, 8'hF0, 8'h44, 8'h20, 8'h00);
        run("R5", 3'd4, 2'd2, 1'b1, 1'b0, 16'h0300, 8'h10, 8'h44, 8'h00, 8'h05);
        run("R6", 3'd5, 2'd1, 1'b0, 1'b0, 16'h0300, 8'hF0, 8'h00, 8'h0F, 8'h00);
        run("R6", 3'd5, 2'd2, 1'b1, 1'b0, 16'h0300, 8'h20, 8'h00, 8'h04, 8'h77);
        run("R7", 3'd6, 2'd1, 1'b0, 1'b0, 16'h0300, 8'h40, 8'h00, 8'h00, 8'hC0);
        run("R7", 3'd6, 2'd1, 1'b0, 1'b0, 16'h0300, 8'hFF, 8'h00, 8'h11, 8'hFF);
        run("R8", 3'd5, 2'd1, 1'b0, 1'b0, 16'h0300, 8'h10, 8'h00, 8'h05, 8'h00);
        run("R8", 3'd6, 2'd3, 1'b0, 1'b0, 16'h0300, 8'h9A, 8'h00, 8'h00, 8'h01);
        run("R9", 3'd7, 2'd1, 1'b0, 1'b1, 16'h1000, 8'h80, 8'h00, 8'h00, 8'h00);
        run("R9", 3'd7, 2'd3, 1'b0, 1'b1, 16'h1000, 8'h05, 8'h00, 8'h00, 8'h00);
        run("R9", 3'd7, 2'd2, 1'b0, 1'b0, 16'h1000, 8'h05, 8'h00, 8'h00, 8'h00);
        run("R11", 3'd1, 2'd3, 1'b0, 1'b0, 16'h0400, 8'hCD, 8'hAB, 8'h00, 8'h00);
        run("R11", 3'd4, 2'd2, 1'b0, 1'b0, 16'h0400, 8'h7F, 8'h00, 8'h01, 8'h00);
        run("R11", 3'd2, 2'd3, 1'b1, 1'b0, 16'h0400, 8'hFF, 8'h20, 8'h00, 8'h01);

        // R12: start pulses during a pointer sequence and during write-back are ignored
        cur_req = "R12";
        launch(3'd6, 2'd3, 1'b0, 1'b0, 16'h0500, 8'h30, 8'h00, 8'h00, 8'h08);
        mode = 3'd0; kind = 2'd1; pc = 16'h7777; lo = 8'h01; yv = 8'hEE;
        start = 1'b1; tick(); start = 1'b0;
        tick();
        start = 1'b1; tick(); start = 1'b0;
        tick();
        start = 1'b1; tick(); start = 1'b0;
        drain();

        // R10: back-to-back accesses, each done is a single cycle
        run("R10", 3'd3, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h01, 8'h00, 8'h00, 8'h00);
        run("R10", 3'd5, 2'd3, 1'b0, 1'b0, 16'h0000, 8'h7F, 8'h00, 8'h80, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule